// File: doc/BRIEF.md
# Reset-Time Port Option Loader

This block sits between the reset pin and the processor core. Once reset is released, it walks the option region at the top of a 64K program memory, one byte per clock, through a plain synchronous read port. The region is 256 bytes, starting at FF00H. Four of those bytes are turned into per-pin pad settings:

- the output style (push-pull or open-drain) for each bit of ports 0, 1 and 3;
- the pull-up enables for port 0, which are set one nibble at a time.

The core is held off until two things are done: the whole region has been read, and a programmable hold-off period has run out. The hold-off period is counted in clock cycles.

When the block raises its run enable, the core begins fetching at address 0000H. Program code lives in 0000H to EFFFH, so the loader never reads there. The pad settings come out as plain vectors that the port logic uses directly.

Top module: `opt_boot_loader`

## Requirements
- R1: After reset is released, the loader issues exactly AREA_BYTES reads, one per clock. The addresses run from FF00H upward in steps of one, and no read address is ever below FF00H.
- R2: Read data is taken on the clock after its request. Bit n of byte 0 sets port 0 bit n, byte 1 sets port 1, and byte 2 sets port 3. In each case a 1 selects push-pull output and a 0 selects open-drain.
- R3: In byte 3, bit 0 enables the pull-ups of port 0 bits 3..0 and bit 1 enables those of bits 7..4 (1 = enabled). Bits 7..2 of byte 3 and all bytes from 4 upward change no output.
- R4: A port 0 bit that is open-drain reports no pull-up, whatever its nibble enable says.
- R5: `core_run` is low until the last read has been captured and HOLDOFF_CYC cycles have elapsed. Counting clock edges from release, it first goes high on edge max(AREA_BYTES+2, HOLDOFF_CYC+1).
- R6: Once high, `core_run` stays high, and the configuration outputs stay unchanged, until reset.
- R7: While reset is low (asynchronous, active low), every configuration output is 0 (open-drain, no pull-up), `core_run` is 0 and no read is issued. Asserting reset during loading restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd_en | output | 1 | Read request to program memory |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| core_run | output | 1 | Releases the core to fetch from 0000H |
| p0_cmos | output | 8 | Port 0 push-pull select per bit |
| p1_cmos | output | 8 | Port 1 push-pull select per bit |
| p3_cmos | output | 8 | Port 3 push-pull select per bit |
| p0_pullup | output | 8 | Port 0 effective pull-up per bit |

## Verification
The in-line properties check several things on every cycle:

- every read address stays inside the option region and rises by one from the previous read;
- no read is issued once the core runs;
- the run enable never falls outside reset;
- the pad settings are frozen while the core runs.

Only the scenarios can show the following:

- the byte-to-port decoding;
- that ignored bytes and bits have no effect;
- the exact edge on which the core is released under a dominant hold-off and under a dominant read sequence;
- that a reset in the middle of loading clears the settings and reruns the sequence with new data.

// File: rtl/opt_boot_loader.sv
module opt_boot_loader #(
  parameter int AW          = 16,
  parameter int AREA_BASE   = 16'hFF00,
  parameter int AREA_BYTES  = 256,
  parameter int HOLDOFF_CYC = 24000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          core_run,
  output logic [7:0]    p0_cmos,
  output logic [7:0]    p1_cmos,
  output logic [7:0]    p3_cmos,
  output logic [7:0]    p0_pullup
);
  localparam int CW = $clog2(AREA_BYTES + 1);
  localparam int IW = $clog2(AREA_BYTES);
  localparam int HW = $clog2(HOLDOFF_CYC + 2);

  logic [CW-1:0] rd_cnt;
  logic [IW-1:0] cap_idx;
  logic          cap_vld;
  logic [HW-1:0] hold_cnt;
  logic [1:0]    pu_nib;
  logic          reads_done, hold_done;

  assign reads_done = (rd_cnt == CW'(AREA_BYTES));
  assign hold_done  = (hold_cnt >= HW'(HOLDOFF_CYC));
  assign mem_rd_en  = rst_n & ~reads_done;
  assign mem_addr   = AW'(AREA_BASE) + AW'(rd_cnt);
  assign p0_pullup  = {{4{pu_nib[1]}}, {4{pu_nib[0]}}} & p0_cmos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt   <= '0;
      cap_vld  <= 1'b0;
      cap_idx  <= '0;
      hold_cnt <= '0;
      core_run <= 1'b0;
    end else begin
      cap_vld <= mem_rd_en;
      cap_idx <= rd_cnt[IW-1:0];
      if (!reads_done) rd_cnt <= rd_cnt + CW'(1);
      if (!hold_done) hold_cnt <= hold_cnt + HW'(1);
      if (reads_done && !cap_vld && hold_done) core_run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_cmos <= '0;
      p1_cmos <= '0;
      p3_cmos <= '0;
      pu_nib  <= '0;
    end else if (cap_vld) begin
      case (cap_idx)
        IW'(0): p0_cmos <= mem_rdata;
        IW'(1): p1_cmos <= mem_rdata;
        IW'(2): p3_cmos <= mem_rdata;
        IW'(3): pu_nib  <= mem_rdata[1:0];
        default: ;
      endcase
    end
  end

  AST_RD_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_addr >= AW'(AREA_BASE)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> mem_addr == $past(mem_addr) + AW'(1)); // R1
  AST_NO_READ_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> !mem_rd_en); // R5
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> ($stable(p0_cmos) && $stable(p1_cmos) && $stable(p3_cmos) && $stable(p0_pullup))); // R6
endmodule

// File: tb/opt_boot_loader_tb.sv
module opt_boot_loader_tb_top;
  localparam int HOLD_SLOW = 300;
  localparam int HOLD_FAST = 8;
  localparam int NVEC = 6;
  // {byte0, byte1, byte2, byte3, fill}
  localparam logic [39:0] VEC [NVEC] = '{
    40'h00_00_00_00_00,
    40'hFF_FF_FF_03_FF,
    40'hA5_3C_0F_01_5A,
    40'hA5_3C_0F_01_C3,
    40'hF0_81_7E_FE_FF,
    40'h3C_55_AA_FD_00
  };

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic [7:0] opt [256];
  logic        rd_a, rd_b, run_a, run_b;
  logic [15:0] addr_a, addr_b;
  logic [7:0]  rdata_a, rdata_b;
  logic [7:0]  c0_a, c1_a, c3_a, pu_a, c0_b, c1_b, c3_b, pu_b;

  int checks = 0, fails = 0;
  int nrd_a = 0, bad_a = 0;

  opt_boot_loader #(.HOLDOFF_CYC(HOLD_SLOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(rd_a), .mem_addr(addr_a), .mem_rdata(rdata_a),
    .core_run(run_a), .p0_cmos(c0_a), .p1_cmos(c1_a), .p3_cmos(c3_a), .p0_pullup(pu_a));

  opt_boot_loader #(.HOLDOFF_CYC(HOLD_FAST)) dut_fast (
    .clk(clk), .rst_n(rst_n), .mem_rd_en(rd_b), .mem_addr(addr_b), .mem_rdata(rdata_b),
    .core_run(run_b), .p0_cmos(c0_b), .p1_cmos(c1_b), .p3_cmos(c3_b), .p0_pullup(pu_b));

  always @(posedge clk) begin
    if (!rst_n) begin
      nrd_a = 0;
    end else if (rd_a) begin
      if (addr_a != 16'hFF00 + 16'(nrd_a)) bad_a = bad_a + 1;
      nrd_a = nrd_a + 1;
    end
    if (rd_a) rdata_a <= opt[addr_a[7:0]];
    if (rd_b) rdata_b <= opt[addr_b[7:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic fill(input logic [39:0] v);
    for (int k = 0; k < 256; k++) opt[k] = v[7:0] ^ 8'(k);
    opt[0] = v[39:32]; opt[1] = v[31:24]; opt[2] = v[23:16]; opt[3] = v[15:8];
  endtask

  task automatic run_load(output int fa, output int fb);
    fa = 0; fb = 0;
    @(negedge clk); rst_n = 1;
    for (int n = 1; n < 2000; n++) begin
      @(posedge clk); @(negedge clk);
      if (run_a && fa == 0) fa = n;
      if (run_b && fb == 0) fb = n;
      if (fa != 0 && fb != 0) break;
    end
  endtask

  task automatic check_cfg(input logic [39:0] v, input string tag);
    logic [7:0] b0, b1, b2, b3, pu;
    b0 = v[39:32]; b1 = v[31:24]; b2 = v[23:16]; b3 = v[15:8];
    pu = {{4{b3[1]}}, {4{b3[0]}}} & b0;
    chk({"R2 p0 ", tag}, c0_a, b0);
    chk({"R2 p1 ", tag}, c1_a, b1);
    chk({"R2 p3 ", tag}, c3_a, b2);
    chk({"R3 R4 pullup ", tag}, pu_a, pu);
    chk({"R3 fast p0/pu ", tag}, {c0_b, pu_b}, {b0, pu});
  endtask

  initial begin
    #900000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int fa, fb;
    fill(VEC[1]);
    repeat (3) @(negedge clk);
    chk("R7 reset outputs", {run_a, rd_a, c0_a, c1_a, c3_a, pu_a}, '0);

    for (int i = 0; i < NVEC; i++) begin
      fill(VEC[i]);
      @(negedge clk); rst_n = 0;
      @(negedge clk);
      run_load(fa, fb);
      chk("R5 release edge slow", fa, HOLD_SLOW + 1);
      chk("R5 release edge fast", fb, 258);
      chk("R1 read count", nrd_a, 256);
      chk("R1 address order", bad_a, 0);
      check_cfg(VEC[i], $sformatf("vec%0d", i));
      for (int k = 0; k < 256; k++) opt[k] = ~opt[k];
      repeat (20) @(negedge clk);
      chk("R6 run held", {run_a, run_b}, 2'b11);
      check_cfg(VEC[i], $sformatf("vec%0d frozen", i));
    end

    // R7: reset in the middle of loading
    fill(VEC[1]);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (100) @(negedge clk);
    chk("R7 mid-load partial cfg", c0_a, 8'hFF);
    rst_n = 0;
    #1;
    chk("R7 mid-load clear", {run_a, rd_a, c0_a, c1_a, c3_a, pu_a}, '0);
    fill(VEC[2]);
    @(negedge clk);
    run_load(fa, fb);
    chk("R7 restart release slow", fa, HOLD_SLOW + 1);
    chk("R7 restart release fast", fb, 258);
    chk("R7 restart reads", nrd_a, 256);
    check_cfg(VEC[2], "restart");
    report();
  end
endmodule